// File: doc/BRIEF.md
# Watchdog Timer with Reset Generator

This block is a software-serviced watchdog. An 8-bit up-counter advances once for each cycle in which the count-tick input is high and the timer is enabled. Software must rewrite the counter, usually with zero, often enough that it never steps past its top value. If it does wrap from all-ones to zero in watchdog mode, the block raises an overflow output for a fixed number of clock cycles. It sets a sticky flag. When reset generation is enabled, it also drives an internal reset pulse, tagged as power-on or manual. In interval mode the same wrap only raises a one-cycle interrupt request.

Software reaches the block through a small register port. Address 0 is the counter. Address 1 holds the control bits. Address 2 holds the reset-control bits and the flag. The overflow pulse is two cycles longer when reset generation is enabled. An external reset input clears the whole block. It wins over an overflow that happens in the same cycle.

Top module: `wdog_rstgen`

## Requirements
- R1: After the system reset, all four addresses read 0, and `ovf_o`, `int_rst_o`, `rst_kind_o` and `irq_o` are low.
- R2: The counter (address 0) goes up by one only on a clock edge where `tick_i` is 1 and the enable bit (address 1, bit 0) is 1. Otherwise it keeps its value.
- R3: A write to address 0 loads the counter and takes precedence over a tick in the same cycle. Rewriting the counter before it passes 0xFF means no overflow is reported.
- R4: In watchdog mode (address 1, bit 1 = 1, bit 0 = 1), a tick at count 0xFF wraps the counter to 0. From the next cycle, `ovf_o` is high for 132 cycles if reset-enable (address 2, bit 0) is 1, or for 130 cycles if it is 0.
- R5: With reset-enable at 1, `int_rst_o` rises in the same cycle as `ovf_o` and stays high for 518 cycles. During that pulse, `rst_kind_o` equals the reset-select bit (address 2, bit 1: 1 = manual, 0 = power-on). With reset-enable at 0, `int_rst_o` stays low.
- R6: A watchdog-mode overflow sets the flag (address 2, bit 7), and the flag stays set.
- R7: Writing 0 to bit 7 of address 2 clears the flag only after a read access (`rd_en` high) of address 2 that returned the flag as 1. Without that read, or when bit 7 is written as 1, the flag is unchanged.
- R8: `ext_rst_i` clears the counter, all control bits and the flag, and ends any running pulses. If it comes in the same cycle as an overflow, neither pulse starts and the flag reads 0.
- R9: In interval mode (address 1, bit 1 = 0), an overflow raises `irq_o` for exactly one cycle, starting the cycle after the wrap. It does not raise `ovf_o` or `int_rst_o`, and it does not set the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| ext_rst_i | input | 1 | Synchronous external reset, has priority over overflow |
| tick_i | input | 1 | Count-enable tick from the prescaler |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read access strobe (arms flag clearing) |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register, combinational |
| ovf_o | output | 1 | Overflow output pulse |
| int_rst_o | output | 1 | Internal reset pulse |
| rst_kind_o | output | 1 | Internal reset type, 1 = manual, 0 = power-on |
| irq_o | output | 1 | Interval-mode interrupt request, one cycle |

## Verification
Overflow is driven from three set-ups: reset-enable on with manual type, reset-enable on with power-on type, and reset-enable off. The measured pulse lengths and the reset type show whether the length choice and the type tag follow the right bits. Periodic servicing, and a counter write that lands on the same edge as a terminal tick, show whether a rewrite really wins over the wrap. An external reset that coincides with a wrap and one that arrives mid-pulse show whether it has priority. An interval-mode wrap shows that the mode bit steers the event to the interrupt alone.

// File: rtl/wdog_pkg.sv
`timescale 1ns/1ps
package wdog_pkg;

  typedef enum logic [1:0] {
    REG_COUNT = 2'd0,
    REG_CTRL  = 2'd1,
    REG_RCTL  = 2'd2,
    REG_NONE  = 2'd3
  } wdog_reg_e;

  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_WD_BIT  = 1;
  localparam int RC_EN_BIT   = 0;
  localparam int RC_KIND_BIT = 1;

  // Overflow pulse length depends on whether reset generation is on.
  function automatic int unsigned pick_ovf_len(input logic rst_en,
                                               input int unsigned len_rst,
                                               input int unsigned len_norst);
    return rst_en ? len_rst : len_norst;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/wdog_counter.sv
`timescale 1ns/1ps
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic             tick,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);

  function automatic logic at_top(input logic [CNT_W-1:0] v);
    return &v;
  endfunction

  logic step;
  assign step = en & tick;
  // A wrap only counts when no write or clear replaces the value.
  assign wrap = step & at_top(cnt) & ~wr & ~clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (clr)    cnt <= '0;
    else if (wr)     cnt <= wdata;
    else if (step)   cnt <= cnt + 1'b1;
  end

  assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !wr && !step) |=> (cnt == $past(cnt)));

  assert_write_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr) |=> (cnt == $past(wdata)));

  assert_wrap_to_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));

endmodule

// File: rtl/wdog_pulse.sv
`timescale 1ns/1ps
module wdog_pulse #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             start,
  input  logic [LEN_W-1:0] len,
  output logic             active
);

  logic [LEN_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              remain <= '0;
    else if (clr)            remain <= '0;
    else if (start)          remain <= len;
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign active = (remain != '0);

  assert_pulse_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !clr && (len != '0)) |=> active);

  assert_pulse_needs_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(start));

endmodule

// File: rtl/wdog_regs.sv
`timescale 1ns/1ps
module wdog_regs #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             wr_ctl,
  input  logic             wr_rctl,
  input  logic             rd_rctl,
  input  logic             w_en,
  input  logic             w_wd,
  input  logic             w_rc_en,
  input  logic             w_rc_kind,
  input  logic             w_flag,
  input  logic             flag_set,
  output logic             ctl_en,
  output logic             ctl_wd,
  output logic             rc_en,
  output logic             rc_kind,
  output logic             flag
);

  logic armed;
  logic flag_clr;

  // A clear needs a prior read that returned the flag as 1.
  assign flag_clr = wr_rctl & ~w_flag & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en <= 1'b0; ctl_wd <= 1'b0;
    end else if (clr) begin
      ctl_en <= 1'b0; ctl_wd <= 1'b0;
    end else if (wr_ctl) begin
      ctl_en <= w_en; ctl_wd <= w_wd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rc_en <= 1'b0; rc_kind <= 1'b0;
    end else if (clr) begin
      rc_en <= 1'b0; rc_kind <= 1'b0;
    end else if (wr_rctl) begin
      rc_en <= w_rc_en; rc_kind <= w_rc_kind;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag <= 1'b0; armed <= 1'b0;
    end else if (clr) begin
      flag <= 1'b0; armed <= 1'b0;
    end else if (flag_set) begin
      flag <= 1'b1;
    end else if (flag_clr) begin
      flag <= 1'b0; armed <= 1'b0;
    end else if (rd_rctl && flag) begin
      armed <= 1'b1;
    end
  end

  assert_ext_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!flag && !ctl_en && !ctl_wd && !rc_en && !rc_kind));

  assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr && !wr_rctl) |=> flag);

  assert_clear_needs_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> ($past(armed) || $past(clr)));

endmodule

// File: rtl/wdog_rstgen.sv
`timescale 1ns/1ps
module wdog_rstgen #(
  parameter int CNT_W         = 8,
  parameter int OVF_LEN_RST   = 132,
  parameter int OVF_LEN_NORST = 130,
  parameter int RST_LEN       = 518
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_rst_i,
  input  logic             tick_i,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  output logic             ovf_o,
  output logic             int_rst_o,
  output logic             rst_kind_o,
  output logic             irq_o
);
  import wdog_pkg::*;

  localparam int OVF_MAX = int'(max_u(OVF_LEN_RST, OVF_LEN_NORST));
  localparam int OVF_W   = $clog2(OVF_MAX + 1);
  localparam int RST_W   = $clog2(RST_LEN + 1);
  localparam int FLAG_BIT = CNT_W - 1;

  logic [CNT_W-1:0] cnt;
  logic             wrap;
  logic             wr_cnt, wr_ctl, wr_rctl, rd_rctl;
  logic             ctl_en, ctl_wd, rc_en, rc_kind, flag;
  logic             wd_ovf, iv_ovf, rst_start;
  logic [OVF_W-1:0] ovf_len;
  logic [RST_W-1:0] rst_len;
  logic             irq_q, kind_q;

  assign wr_cnt  = wr_en & (addr == REG_COUNT);
  assign wr_ctl  = wr_en & (addr == REG_CTRL);
  assign wr_rctl = wr_en & (addr == REG_RCTL);
  assign rd_rctl = rd_en & (addr == REG_RCTL);

  wdog_counter #(.CNT_W(CNT_W)) i_counter (
    .clk(clk), .rst_n(rst_n), .clr(ext_rst_i), .en(ctl_en), .tick(tick_i),
    .wr(wr_cnt), .wdata(wdata), .cnt(cnt), .wrap(wrap)
  );

  // Named events for assertions: a wrap steered by the mode bit.
  assign wd_ovf    = wrap & ctl_wd & ~ext_rst_i;
  assign iv_ovf    = wrap & ~ctl_wd & ~ext_rst_i;
  assign rst_start = wd_ovf & rc_en;

  wdog_regs #(.CNT_W(CNT_W)) i_regs (
    .clk(clk), .rst_n(rst_n), .clr(ext_rst_i),
    .wr_ctl(wr_ctl), .wr_rctl(wr_rctl), .rd_rctl(rd_rctl),
    .w_en(wdata[CTL_EN_BIT]), .w_wd(wdata[CTL_WD_BIT]),
    .w_rc_en(wdata[RC_EN_BIT]), .w_rc_kind(wdata[RC_KIND_BIT]),
    .w_flag(wdata[FLAG_BIT]), .flag_set(wd_ovf),
    .ctl_en(ctl_en), .ctl_wd(ctl_wd), .rc_en(rc_en), .rc_kind(rc_kind), .flag(flag)
  );

  assign ovf_len = OVF_W'(pick_ovf_len(rc_en, OVF_LEN_RST, OVF_LEN_NORST));
  assign rst_len = RST_W'(RST_LEN);

  wdog_pulse #(.LEN_W(OVF_W)) i_ovf_pulse (
    .clk(clk), .rst_n(rst_n), .clr(ext_rst_i), .start(wd_ovf),
    .len(ovf_len), .active(ovf_o)
  );

  wdog_pulse #(.LEN_W(RST_W)) i_rst_pulse (
    .clk(clk), .rst_n(rst_n), .clr(ext_rst_i), .start(rst_start),
    .len(rst_len), .active(int_rst_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0; kind_q <= 1'b0;
    end else begin
      irq_q <= iv_ovf;
      if (ext_rst_i)      kind_q <= 1'b0;
      else if (rst_start) kind_q <= rc_kind;
    end
  end

  assign irq_o      = irq_q;
  assign rst_kind_o = kind_q & int_rst_o;

  always_comb begin
    rdata = '0;
    case (addr)
      REG_COUNT: rdata = cnt;
      REG_CTRL: begin
        rdata[CTL_EN_BIT] = ctl_en;
        rdata[CTL_WD_BIT] = ctl_wd;
      end
      REG_RCTL: begin
        rdata[RC_EN_BIT]   = rc_en;
        rdata[RC_KIND_BIT] = rc_kind;
        rdata[FLAG_BIT]    = flag;
      end
      default: rdata = '0;
    endcase
  end

  assert_ovf_starts_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ovf |=> ovf_o);

  assert_rst_follows_en_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wd_ovf |=> (int_rst_o == $past(rc_en)));

  assert_ext_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ext_rst_i |=> (!ovf_o && !int_rst_o && !irq_o));

  assert_irq_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);

  assert_irq_only_interval_R9: assert property (@(posedge clk) disable iff (!rst_n)
    iv_ovf |=> (irq_o && !flag));

endmodule

// File: tb/test_wdog_rstgen.sv
`timescale 1ns/1ps
module test_wdog_rstgen;

  logic       clk = 1'b0;
  logic       rst_n, ext_rst_i, tick_i, wr_en, rd_en;
  logic [1:0] addr;
  logic [7:0] wdata, rdata;
  logic       ovf_o, int_rst_o, rst_kind_o, irq_o;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  wdog_rstgen i_wdog_rstgen (
    .clk(clk), .rst_n(rst_n), .ext_rst_i(ext_rst_i), .tick_i(tick_i),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ovf_o(ovf_o), .int_rst_o(int_rst_o), .rst_kind_o(rst_kind_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    addr = a; #0.5; v = rdata;
  endtask

  task automatic rreg(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #0.5; v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick_i = 1'b1;
    repeat (n) @(negedge clk);
    tick_i = 1'b0;
  endtask

  // One tick at 0xFF, then count high samples of both pulses.
  task automatic overflow_measure(output int n_ovf, output int n_rst,
                                  output logic both_first, output logic kind_first);
    n_ovf = 0; n_rst = 0;
    wreg(2'd0, 8'hFF);
    ticks(1);
    both_first = ovf_o & int_rst_o;
    kind_first = rst_kind_o;
    for (int i = 0; i < 600; i++) begin
      if (ovf_o) n_ovf++;
      if (int_rst_o) n_rst++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      peek(2'(a), v);
      chk("R1", $sformatf("addr %0d after reset", a), v, 0);
    end
    chk("R1", "outputs after reset", {ovf_o, int_rst_o, rst_kind_o, irq_o}, 0);
  endtask

  task automatic t_count();
    logic [7:0] v;
    wreg(2'd0, 8'h05);
    ticks(10);
    peek(2'd0, v); chk("R2", "count held while disabled", v, 5);
    wreg(2'd1, 8'h01);
    ticks(3);
    peek(2'd0, v); chk("R2", "count after 3 ticks", v, 8);
    repeat (5) @(negedge clk);
    peek(2'd0, v); chk("R2", "count held with tick low", v, 8);
  endtask

  task automatic t_service();
    logic [7:0] v;
    logic seen = 1'b0;
    wreg(2'd1, 8'h03);
    wreg(2'd2, 8'h01);
    wreg(2'd0, 8'hF0);
    for (int k = 0; k < 4; k++) begin
      ticks(14);
      if (ovf_o) seen = 1'b1;
      wreg(2'd0, 8'hF0);
    end
    chk("R3", "no overflow with servicing", seen, 0);
    peek(2'd2, v); chk("R3", "flag clear with servicing", v[7], 0);
    wreg(2'd0, 8'hFF);
    @(negedge clk); tick_i = 1'b1; addr = 2'd0; wdata = 8'h10; wr_en = 1'b1;
    @(negedge clk); tick_i = 1'b0; wr_en = 1'b0;
    chk("R3", "write beats terminal tick, ovf", ovf_o, 0);
    peek(2'd0, v); chk("R3", "write beats terminal tick, count", v, 8'h10);
  endtask

  task automatic t_wd_rst();
    int no, nr; logic bf, kf; logic [7:0] v;
    wreg(2'd2, 8'h03);
    overflow_measure(no, nr, bf, kf);
    chk("R4", "ovf length with reset on", no, 132);
    chk("R5", "internal reset length", nr, 518);
    chk("R5", "ovf and reset rise together", bf, 1);
    chk("R5", "reset kind manual", kf, 1);
    peek(2'd0, v); chk("R4", "counter wrapped", v, 0);
    peek(2'd2, v); chk("R6", "flag set after overflow", v[7], 1);
  endtask

  task automatic t_flag();
    logic [7:0] v;
    wreg(2'd2, 8'h03);
    peek(2'd2, v); chk("R7", "flag kept without read", v[7], 1);
    rreg(2'd2, v);
    wreg(2'd2, 8'h83);
    peek(2'd2, v); chk("R7", "flag kept on write of 1", v[7], 1);
    wreg(2'd2, 8'h03);
    peek(2'd2, v); chk("R7", "flag cleared after read", v[7], 0);
  endtask

  task automatic t_wd_norst();
    int no, nr; logic bf, kf; logic [7:0] v;
    wreg(2'd2, 8'h00);
    overflow_measure(no, nr, bf, kf);
    chk("R4", "ovf length with reset off", no, 130);
    chk("R5", "no internal reset when off", nr, 0);
    peek(2'd2, v); chk("R6", "flag set, reset off", v[7], 1);
    wreg(2'd2, 8'h01);
    overflow_measure(no, nr, bf, kf);
    chk("R5", "reset kind power-on", kf, 0);
    chk("R5", "power-on reset length", nr, 518);
  endtask

  task automatic t_ext();
    logic [7:0] v;
    wreg(2'd2, 8'h03);
    wreg(2'd0, 8'hFF);
    @(negedge clk); tick_i = 1'b1; ext_rst_i = 1'b1;
    @(negedge clk); tick_i = 1'b0; ext_rst_i = 1'b0;
    chk("R8", "no pulses on coincident ext reset", {ovf_o, int_rst_o}, 0);
    peek(2'd2, v); chk("R8", "flag and reset control cleared", v, 0);
    peek(2'd1, v); chk("R8", "control cleared", v, 0);
    peek(2'd0, v); chk("R8", "counter cleared", v, 0);
    wreg(2'd1, 8'h03);
    wreg(2'd2, 8'h01);
    wreg(2'd0, 8'hFF);
    ticks(1);
    repeat (10) @(negedge clk);
    chk("R8", "pulses running before ext reset", {ovf_o, int_rst_o}, 3);
    ext_rst_i = 1'b1;
    @(negedge clk); ext_rst_i = 1'b0;
    chk("R8", "pulses ended by ext reset", {ovf_o, int_rst_o}, 0);
  endtask

  task automatic t_interval();
    logic [7:0] v;
    wreg(2'd1, 8'h01);
    wreg(2'd2, 8'h01);
    wreg(2'd0, 8'hFF);
    ticks(1);
    chk("R9", "irq raised", irq_o, 1);
    chk("R9", "no ovf or reset in interval mode", {ovf_o, int_rst_o}, 0);
    @(negedge clk);
    chk("R9", "irq lasts one cycle", irq_o, 0);
    peek(2'd2, v); chk("R9", "flag untouched in interval mode", v[7], 0);
  endtask

  initial begin
    rst_n = 1'b0; ext_rst_i = 1'b0; tick_i = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; addr = 2'd0; wdata = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_count();
    t_service();
    t_wd_rst();
    t_flag();
    t_wd_norst();
    t_ext();
    t_interval();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule